// File: doc/BRIEF.md
# Multiplier Operand Register Stage with Tap Chain and Product Feedback

This block is the registered operand front end for one half of a multiply slice. That half holds four 18-bit multipliers. For each multiplier it holds one A operand register and one B operand register and presents them to the multipliers downstream. The multipliers, adders and accumulators are not part of the block.

An elaboration-time mode code fixes what each register loads. Code 0 is parallel: the register takes its own general input. Code 1 is shift: the register takes the previous A register in the chain, and A lane 0 takes the cascade input. Code 2 is loopback: the register takes the upper half of the registered product. Only the A registers may use shift mode. Only B lane 0 may use loopback, so at most one feedback path exists per half slice. Any other combination stops elaboration with an error.

The default build loads A lane 0 in parallel and chains A lanes 1 to 3 behind it. This forms a four-tap delay line for FIR work. B lane 0 uses loopback for recursive filters, and B lanes 1 to 3 load in parallel.

Top module: `mult_opreg_half`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every A and B operand register clears to zero, so `a_out`, `b_out` and `shift_out` read zero after that edge.
- R2: With `rst_n` high, `clr` high at a rising edge zeroes every operand register, whether `ce` is high or low.
- R3: With `clr` low and `ce` low, every operand register keeps its value. This includes the chained A registers and the loopback B register.
- R4: A register in parallel mode (code 0) loads its own lane of `a_in` or `b_in` on the edge where `ce` is high. Lane i occupies bits [18i+17:18i]. In the default build this applies to A lane 0 and B lanes 1 to 3.
- R5: An A register in shift mode (code 1) loads the value A register i-1 held before the edge. A lane 0 in shift mode loads `shift_in`. In the default build, a value loaded into A lane 0 reaches A lane k after k further enabled edges.
- R6: `shift_out` always equals A lane 3, the last register of the chain, so slices can be cascaded.
- R7: B lane 0 in loopback mode (code 2) loads `prod_fb[35:18]` on an edge where `ce` and `prod_fb_vld` are both high.
- R8: B lane 0 in loopback mode keeps its value when `prod_fb_vld` is low. After reset it therefore stays zero until the first valid product is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of all operand registers |
| ce | input | 1 | Clock enable for all operand registers |
| a_in | input | 72 | General A inputs, lane i at bits [18i+17:18i] |
| b_in | input | 72 | General B inputs, lane i at bits [18i+17:18i] |
| shift_in | input | 18 | Cascade input to the A chain from the preceding slice |
| prod_fb | input | 36 | Registered product of the first multiplier, used for feedback |
| prod_fb_vld | input | 1 | Marks `prod_fb` as holding a valid product |
| a_out | output | 72 | Registered A operands, one lane per multiplier |
| b_out | output | 72 | Registered B operands, one lane per multiplier |
| shift_out | output | 18 | Last A register, feeding the next slice's chain |

## Verification
The hardest state to reach is a full delay line whose contents must survive a stall and then be wiped by a clear that arrives while `ce` is low. To reach it, the stimulus loads a distinct value on every enabled cycle so that each tap holds something different. It then drops `ce` for a cycle, with the feedback input still marked valid and the product value changed, so that an accidental load would show. After that it asserts `clr` while `ce` stays low. A second difficult case is the loopback register just after reset. Here the stimulus drives a non-zero product with `prod_fb_vld` low for several enabled cycles and confirms that B lane 0 stays zero until the first valid product is applied.

// File: rtl/mopr_pkg.sv
// Shared mode encoding for the multiplier operand register stage.
// Assumes: codes are fixed at elaboration; code 3 is never legal.
package mopr_pkg;

    typedef enum logic [1:0] {
        OPM_PARALLEL = 2'd0,
        OPM_SHIFT    = 2'd1,
        OPM_LOOP     = 2'd2
    } opmode_e;

endpackage

// File: rtl/mopr_cell.sv
// One operand register with its static input source.
// What it does: loads the general input, the chain input or the feedback
// input, as chosen by MODE, under clock enable.
// Assumes: rst_n is synchronous and active low and takes priority over clr;
// clr takes priority over ce; the loopback load also needs loop_vld.
module mopr_cell
    import mopr_pkg::*;
#(
    parameter int      W    = 18,
    parameter opmode_e MODE = OPM_PARALLEL
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ce,
    input  logic [W-1:0] par_d,
    input  logic [W-1:0] chain_d,
    input  logic [W-1:0] loop_d,
    input  logic         loop_vld,
    output logic [W-1:0] q
);

    logic [W-1:0] next_d;
    logic         load;
    logic         unused_sink;

    // Inputs that this mode does not use are reduced into a sink.
    assign unused_sink = ^{par_d, chain_d, loop_d, loop_vld};

    // Pick the data source and the load condition for the configured mode.
    always_comb begin
        next_d = par_d;
        load   = ce;
        if (MODE == OPM_SHIFT) begin
            next_d = chain_d;
        end else if (MODE == OPM_LOOP) begin
            next_d = loop_d;
            load   = ce && loop_vld;
        end
    end

    // Operand register: reset, then clear, then a gated load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (load) begin
            q <= next_d;
        end
    end

endmodule

// File: rtl/mopr_a_chain.sv
// Bank of A operand registers. Lanes in shift mode form a delay line.
// What it does: each lane is parallel-loaded or takes the lane below it;
// lane 0 in shift mode takes shift_in. The last lane drives shift_out.
// Assumes: only codes 0 and 1 are legal for A lanes (checked at elaboration).
module mopr_a_chain
    import mopr_pkg::*;
#(
    parameter int             N     = 4,
    parameter int             W     = 18,
    parameter logic [2*N-1:0] MODES = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           ce,
    input  logic [N*W-1:0] par_d,
    input  logic [W-1:0]   shift_in,
    output logic [N*W-1:0] q,
    output logic [W-1:0]   shift_out
);

    for (genvar i = 0; i < N; i++) begin : g_lane
        localparam logic [1:0] CODE = MODES[2*i +: 2];
        localparam opmode_e    M    = opmode_e'(CODE);
        logic [W-1:0] link;

        // Elaboration check: A lanes accept parallel or shift only.
        if (CODE != 2'd0 && CODE != 2'd1) begin : g_bad_mode
            $error("A lane %0d: mode code %0d is not allowed", i, CODE);
        end

        // Chain source: shift_in feeds lane 0, otherwise the lane below.
        if (i == 0) begin : g_head
            assign link = shift_in;
        end else begin : g_body
            assign link = q[(i-1)*W +: W];
        end

        mopr_cell #(
            .W    (W),
            .MODE (M)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .ce       (ce),
            .par_d    (par_d[i*W +: W]),
            .chain_d  (link),
            .loop_d   ({W{1'b0}}),
            .loop_vld (1'b0),
            .q        (q[i*W +: W])
        );
    end

    // The chain tail leaves the slice for cascading.
    assign shift_out = q[(N-1)*W +: W];

endmodule

// File: rtl/mopr_b_bank.sv
// Bank of B operand registers. Lane 0 may take the product feedback.
// What it does: lanes load their general input in parallel; lane 0 in
// loopback mode loads the upper product half when feedback is valid.
// Assumes: shift is illegal on B and loopback is legal on lane 0 only,
// which limits the half slice to a single feedback path.
module mopr_b_bank
    import mopr_pkg::*;
#(
    parameter int             N     = 4,
    parameter int             W     = 18,
    parameter logic [2*N-1:0] MODES = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           ce,
    input  logic [N*W-1:0] par_d,
    input  logic [W-1:0]   fb_hi,
    input  logic           fb_vld,
    output logic [N*W-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_lane
        localparam logic [1:0] CODE = MODES[2*i +: 2];
        localparam opmode_e    M    = opmode_e'(CODE);
        localparam bit         OK   = (CODE == 2'd0) || (CODE == 2'd2 && i == 0);

        // Elaboration check: B lanes never shift; only lane 0 loops back.
        if (!OK) begin : g_bad_mode
            $error("B lane %0d: mode code %0d is not allowed", i, CODE);
        end

        mopr_cell #(
            .W    (W),
            .MODE (M)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .ce       (ce),
            .par_d    (par_d[i*W +: W]),
            .chain_d  ({W{1'b0}}),
            .loop_d   (fb_hi),
            .loop_vld (fb_vld),
            .q        (q[i*W +: W])
        );
    end

endmodule

// File: rtl/mult_opreg_half.sv
// Operand register stage for one half multiply slice (four multipliers).
// What it does: registers the A and B operands under a static per-lane
// mode. The A lanes can form a tap-delay chain; B lane 0 can recirculate
// the upper half of the registered product.
// Assumes: prod_fb is the already-registered product of multiplier 0;
// modes are parameters; rst_n is synchronous and active low.
module mult_opreg_half
    import mopr_pkg::*;
#(
    parameter int               N      = 4,
    parameter int               W      = 18,
    parameter int               PROD_W = 2*W,
    parameter logic [2*N-1:0]   A_MODE = 8'b01_01_01_00,
    parameter logic [2*N-1:0]   B_MODE = 8'b00_00_00_10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ce,
    input  logic [N*W-1:0]    a_in,
    input  logic [N*W-1:0]    b_in,
    input  logic [W-1:0]      shift_in,
    input  logic [PROD_W-1:0] prod_fb,
    input  logic              prod_fb_vld,
    output logic [N*W-1:0]    a_out,
    output logic [N*W-1:0]    b_out,
    output logic [W-1:0]      shift_out
);

    localparam int FB_LSB = PROD_W - W;

    logic [W-1:0] fb_hi;
    logic         unused_fb_lo;

    // Feedback takes the most significant W bits of the product.
    assign fb_hi        = prod_fb[PROD_W-1 -: W];
    assign unused_fb_lo = ^prod_fb[FB_LSB-1:0];

    mopr_a_chain #(
        .N     (N),
        .W     (W),
        .MODES (A_MODE)
    ) u_a_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .ce        (ce),
        .par_d     (a_in),
        .shift_in  (shift_in),
        .q         (a_out),
        .shift_out (shift_out)
    );

    mopr_b_bank #(
        .N     (N),
        .W     (W),
        .MODES (B_MODE)
    ) u_b_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .ce     (ce),
        .par_d  (b_in),
        .fb_hi  (fb_hi),
        .fb_vld (prod_fb_vld),
        .q      (b_out)
    );

endmodule

// File: rtl/mult_opreg_half_chk.sv
// Property checker for mult_opreg_half, attached by the bind at the end.
// Assumes: the same parameters as the instance it is bound to.
module mult_opreg_half_chk #(
    parameter int             N      = 4,
    parameter int             W      = 18,
    parameter int             PROD_W = 2*W,
    parameter logic [2*N-1:0] A_MODE = 8'b01_01_01_00,
    parameter logic [2*N-1:0] B_MODE = 8'b00_00_00_10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              ce,
    input logic [N*W-1:0]    a_in,
    input logic [N*W-1:0]    b_in,
    input logic [W-1:0]      shift_in,
    input logic [PROD_W-1:0] prod_fb,
    input logic              prod_fb_vld,
    input logic [N*W-1:0]    a_out,
    input logic [N*W-1:0]    b_out,
    input logic [W-1:0]      shift_out
);

    // R1: a reset edge leaves every operand at zero.
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (a_out == '0 && b_out == '0 && shift_out == '0));

    // R2: clear zeroes every operand, whatever ce is.
    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (a_out == '0 && b_out == '0));

    // R3: with ce low and no clear, nothing moves.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !clr) |=> ($stable(a_out) && $stable(b_out)));

    // R6: the cascade output tracks the chain tail across edges.
    assert_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (shift_out == a_out[(N-1)*W +: W]));

    for (genvar i = 0; i < N; i++) begin : g_a
        localparam logic [1:0] CODE = A_MODE[2*i +: 2];
        if (CODE == 2'd0) begin : g_par
            // R4: a parallel A lane captures its input.
            assert_a_par_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (ce && !clr) |=> (a_out[i*W +: W] == $past(a_in[i*W +: W])));
        end else if (i > 0) begin : g_shift
            // R5: a chained A lane captures the lane below.
            assert_a_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (ce && !clr) |=> (a_out[i*W +: W] == $past(a_out[(i-1)*W +: W])));
        end else begin : g_head
            // R5: a chained head lane captures the cascade input.
            assert_a_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (ce && !clr) |=> (a_out[W-1:0] == $past(shift_in)));
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_b
        localparam logic [1:0] CODE = B_MODE[2*i +: 2];
        if (CODE == 2'd2) begin : g_loop
            // R7: a valid product reloads the feedback lane.
            assert_b_loop_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (ce && !clr && prod_fb_vld) |=>
                    (b_out[i*W +: W] == $past(prod_fb[PROD_W-1 -: W])));
            // R8: without a valid product the feedback lane holds.
            assert_b_loop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr && !prod_fb_vld) |=> $stable(b_out[i*W +: W]));
        end else begin : g_par
            // R4: a parallel B lane captures its input.
            assert_b_par_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (ce && !clr) |=> (b_out[i*W +: W] == $past(b_in[i*W +: W])));
        end
    end

endmodule

bind mult_opreg_half mult_opreg_half_chk #(
    .N      (N),
    .W      (W),
    .PROD_W (PROD_W),
    .A_MODE (A_MODE),
    .B_MODE (B_MODE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .ce          (ce),
    .a_in        (a_in),
    .b_in        (b_in),
    .shift_in    (shift_in),
    .prod_fb     (prod_fb),
    .prod_fb_vld (prod_fb_vld),
    .a_out       (a_out),
    .b_out       (b_out),
    .shift_out   (shift_out)
);

// File: tb/mult_opreg_half_test.sv
module mult_opreg_half_test;

    localparam int N  = 4;
    localparam int W  = 18;
    localparam int PW = 2*W;

    typedef struct packed {
        logic         ce;
        logic         clr;
        logic         fbv;
        logic [W-1:0] seed;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, 18'h00011},
        '{1'b1, 1'b0, 1'b0, 18'h00222},
        '{1'b1, 1'b0, 1'b1, 18'h03333},
        '{1'b1, 1'b0, 1'b1, 18'h14444},
        '{1'b0, 1'b0, 1'b1, 18'h25555},
        '{1'b1, 1'b0, 1'b0, 18'h36666},
        '{1'b1, 1'b0, 1'b1, 18'h3FFFF},
        '{1'b0, 1'b0, 1'b0, 18'h0A0A0},
        '{1'b1, 1'b1, 1'b1, 18'h12345},
        '{1'b1, 1'b0, 1'b1, 18'h2ABCD},
        '{1'b1, 1'b0, 1'b0, 18'h00001},
        '{1'b1, 1'b0, 1'b1, 18'h20000},
        '{1'b0, 1'b1, 1'b0, 18'h11111},
        '{1'b1, 1'b0, 1'b1, 18'h0F0F0}
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic            clr;
    logic            ce;
    logic [N*W-1:0]  a_in;
    logic [N*W-1:0]  b_in;
    logic [W-1:0]    shift_in;
    logic [PW-1:0]   prod_fb;
    logic            prod_fb_vld;
    logic [N*W-1:0]  a_out;
    logic [N*W-1:0]  b_out;
    logic [W-1:0]    shift_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W-1:0] ma [N];
    logic [W-1:0] mb [N];

    always #5 clk = ~clk;

    mult_opreg_half uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .ce          (ce),
        .a_in        (a_in),
        .b_in        (b_in),
        .shift_in    (shift_in),
        .prod_fb     (prod_fb),
        .prod_fb_vld (prod_fb_vld),
        .a_out       (a_out),
        .b_out       (b_out),
        .shift_out   (shift_out)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Drive one stimulus set; lane values derive from the seed.
    task automatic drive(input logic c, input logic k, input logic v, input logic [W-1:0] s);
        ce          = c;
        clr         = k;
        prod_fb_vld = v;
        shift_in    = s ^ 18'h2D2D2;
        for (int l = 0; l < N; l++) begin
            a_in[l*W +: W] = s ^ W'(l << 4);
            b_in[l*W +: W] = ~s + W'(l);
        end
        prod_fb = {s ^ 18'h15A5A, s ^ 18'h3C3C3};
    endtask

    // Reference behaviour from the requirements (default mode set).
    task automatic model_edge();
        if (clr) begin
            for (int l = 0; l < N; l++) begin ma[l] = '0; mb[l] = '0; end
        end else if (ce) begin
            for (int l = N-1; l > 0; l--) ma[l] = ma[l-1];
            ma[0] = a_in[W-1:0];
            for (int l = 1; l < N; l++) mb[l] = b_in[l*W +: W];
            if (prod_fb_vld) mb[0] = prod_fb[PW-1 -: W];
        end
    endtask

    task automatic compare_all();
        string base;
        base = clr ? "R2" : (!ce ? "R3" : "");
        chk(base != "" ? base : "R4 a lane0", a_out[W-1:0], ma[0]);
        for (int l = 1; l < N; l++)
            chk(base != "" ? base : "R5 a chain", a_out[l*W +: W], ma[l]);
        chk(base != "" ? base : (prod_fb_vld ? "R7 b lane0" : "R8 b lane0"), b_out[W-1:0], mb[0]);
        for (int l = 1; l < N; l++)
            chk(base != "" ? base : "R4 b lane", b_out[l*W +: W], mb[l]);
        chk("R6 shift_out", shift_out, ma[N-1]);
    endtask

    task automatic step(input logic c, input logic k, input logic v, input logic [W-1:0] s);
        drive(c, k, v, s);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic check_zero(input string req);
        for (int l = 0; l < N; l++) begin
            chk(req, a_out[l*W +: W], '0);
            chk(req, b_out[l*W +: W], '0);
        end
        chk(req, shift_out, '0);
    endtask

    initial begin
        for (int l = 0; l < N; l++) begin ma[l] = '0; mb[l] = '0; end
        rst_n = 1'b0;
        drive(1'b1, 1'b0, 1'b1, 18'h3ABCD);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_zero("R1 reset");
        rst_n = 1'b1;

        // R8: non-zero product but no valid flag keeps the feedback lane at zero.
        step(1'b1, 1'b0, 1'b0, 18'h2FFFF);
        step(1'b1, 1'b0, 1'b0, 18'h1EEEE);
        chk("R8 zero until valid", b_out[W-1:0], '0);

        // Stimulus table walk.
        for (int i = 0; i < NV; i++)
            step(VECS[i].ce, VECS[i].clr, VECS[i].fbv, VECS[i].seed);

        // R5/R6: a marker loaded in lane 0 exits shift_out after three more edges.
        step(1'b1, 1'b0, 1'b0, 18'h2468A);
        step(1'b1, 1'b0, 1'b0, 18'h00000);
        step(1'b1, 1'b0, 1'b0, 18'h00000);
        step(1'b1, 1'b0, 1'b0, 18'h00000);
        chk("R5 delay line", shift_out, 18'h2468A);

        // R3: stall with a valid, changed product; nothing may load.
        step(1'b1, 1'b0, 1'b1, 18'h13579);
        step(1'b0, 1'b0, 1'b1, 18'h3F00F);
        chk("R3 loop hold", b_out[W-1:0], 18'h13579 ^ 18'h15A5A);

        // R2: clear while ce is low wipes the full chain.
        step(1'b0, 1'b1, 1'b1, 18'h3F00F);
        check_zero("R2 clear ce low");

        // R1: mid-run reset after loading.
        step(1'b1, 1'b0, 1'b1, 18'h0BEEF);
        step(1'b1, 1'b0, 1'b1, 18'h1CAFE);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_zero("R1 mid-run reset");
        for (int l = 0; l < N; l++) begin ma[l] = '0; mb[l] = '0; end
        rst_n = 1'b1;
        step(1'b1, 1'b0, 1'b0, 18'h00ABC);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule